// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a set of small control registers for a workstation I/O companion device. Software reaches it over a simple synchronous register bus: each request names one of seven regions, an offset within the region, an access size and, for writes, a data word. The block holds a configuration byte, a diagnostic byte, a modem-control byte, two auxiliary bytes, a 16-bit LED word and a 32-bit system-control word. Several of the bits act on the rest of the system rather than only storing a value.

A power-failing input is synchronised and gated by a power-interrupt enable bit. The result is a power-fail flag, and the flag drives an interrupt level. A strobe bit in the first auxiliary byte sends a one-clock terminal-count pulse to a floppy controller. The second auxiliary byte carries a power-off bit, which requests shutdown, and a clear bit that drops the power-fail flag. A trigger bit in the system-control word requests a system reset. The trigger also leaves a status value in that word, and the status value survives the ordinary block reset.

The request port has no back-pressure. A request is taken in every cycle that `req_valid` is high, and no ready signal exists. Read data comes back combinationally in the same cycle as the read request. Requests whose size does not match the region are dropped.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `pwr_irq_o` is high exactly when the power-fail flag (second auxiliary byte, bit 5) is set and the configuration bit 3 (power-interrupt enable) is set. Clearing the enable bit drops the interrupt right after the write.
- R2: The power-fail flag is re-evaluated every cycle. It becomes the synchronised `pwr_fail_i` level ANDed with configuration bit 3, and it is visible SYNC_STAGES+1 rising edges after the input changes. With the enable bit clear, the flag stays 0.
- R3: A first-auxiliary write with bit 1 set drives `tc_pulse_o` high for exactly one clock, starting after the write edge. Bit 1 is never stored and always reads back as 0. The other seven bits are stored.
- R4: A second-auxiliary write stores only write bit 0 (power-off). Bit 1 (clear) is never stored, and when it is written as 1 the power-fail flag is cleared for that cycle. Readback is power-off in bit 0 and the flag in bit 5.
- R5: A second-auxiliary write with bit 0 set drives `shutdown_req_o` high for one clock, starting after the write edge.
- R6: A 32-bit write at offset 0 of the system-control region with bit 0 set loads the word with 0x00000002 and drives `reset_req_o` for one clock. A write with bit 0 clear changes nothing.
- R7: `rst_n` clears the configuration, first and second auxiliary and modem-control registers, and leaves diagnostic, LED and system-control untouched. `por_n` clears every register.
- R8: Access sizes are coded 0 = byte, 1 = 16-bit, 2 = 32-bit. The configuration, diagnostic, modem and both auxiliary regions accept only byte accesses, LED only 16-bit and system-control only 32-bit. Any other size is ignored on a write and reads as 0.
- R9: In the LED and system-control regions, offsets other than 0 read as 0 and writes to them are ignored.
- R10: Region codes are 0 configuration, 1 diagnostic, 2 modem-control, 3 first auxiliary, 4 second auxiliary, 5 LED, 6 system-control. Configuration, diagnostic and modem bytes store and return all 8 written bits. Byte regions ignore the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| por_n | input | 1 | Asynchronous power-on reset, active low, clears all state |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 3 | Region code (R10) |
| req_size | input | 2 | Access size code (R8) |
| req_addr | input | 2 | Byte offset inside the region |
| req_wdata | input | 32 | Write data, right-aligned |
| rd_data | output | 32 | Read data, same cycle as the read request |
| pwr_fail_i | input | 1 | Asynchronous power-failing indication |
| pwr_irq_o | output | 1 | Power-fail interrupt level |
| tc_pulse_o | output | 1 | One-clock floppy terminal-count pulse |
| shutdown_req_o | output | 1 | One-clock shutdown request |
| reset_req_o | output | 1 | One-clock system reset request |

## Verification
The bench builds the block with its defaults: a two-flop synchroniser, 32-bit data and a 16-bit LED word. With two synchroniser stages, the three-edge path from `pwr_fail_i` to the flag is short enough to check cycle by cycle. That path includes the case where a clear write drops the flag for one cycle while the input stays failing and the next evaluation sets it again. The default widths also make every size-mismatch and non-zero-offset corner reachable with a 2-bit offset.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;

  typedef enum logic [2:0] {
    RGN_CFG    = 3'd0,
    RGN_DIAG   = 3'd1,
    RGN_MODEM  = 3'd2,
    RGN_AUX1   = 3'd3,
    RGN_AUX2   = 3'd4,
    RGN_LED    = 3'd5,
    RGN_SYSCTL = 3'd6
  } region_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  localparam int CFG_PWR_EN_BIT = 3;
  localparam int AUX1_TC_BIT    = 1;
  localparam int AUX2_OFF_BIT   = 0;
  localparam int AUX2_CLR_BIT   = 1;
  localparam int AUX2_FLAG_BIT  = 5;
  localparam int SYS_TRIG_BIT   = 0;
  localparam logic [7:0] SYS_STATUS_VAL = 8'h02;

endpackage

// File: rtl/aux_sync_chain.sv
module aux_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sr_q <= '0;
        else         sr_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/aux_pwrfail_unit.sv
module aux_pwrfail_unit (
  input  logic clk,
  input  logic arst_n,
  input  logic fail_sync_i,
  input  logic enable_i,
  input  logic clear_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      flag_q <= 1'b0;
    else if (clear_i) flag_q <= 1'b0;
    else              flag_q <= fail_sync_i & enable_i;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & enable_i;

  AST_FLAG_FROM_INPUT: assert property (@(posedge clk) disable iff (!arst_n)
    flag_q |-> $past(fail_sync_i));  // R2
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!arst_n)
    clear_i |=> !flag_q);  // R4
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_sysctl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LED_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_region,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pwr_fail_i,
  output logic              pwr_irq_o,
  output logic              tc_pulse_o,
  output logic              shutdown_req_o,
  output logic              reset_req_o
);
  localparam int BYTE_W = 8;

  logic blk_rst_n;
  assign blk_rst_n = rst_n & por_n;

  // Access decode
  logic size_ok, acc_wr, acc_rd, at_base;
  always_comb begin
    case (req_region)
      RGN_CFG, RGN_DIAG, RGN_MODEM, RGN_AUX1, RGN_AUX2:
        size_ok = (req_size == SZ_BYTE);
      RGN_LED:    size_ok = (req_size == SZ_HALF);
      RGN_SYSCTL: size_ok = (req_size == SZ_WORD);
      default:    size_ok = 1'b0;
    endcase
  end
  assign acc_wr  = req_valid && size_ok && req_write;
  assign acc_rd  = req_valid && size_ok && !req_write;
  assign at_base = (req_addr == 2'd0);

  logic wr_cfg, wr_diag, wr_modem, wr_aux1, wr_aux2, wr_led, wr_sys;
  assign wr_cfg   = acc_wr && (req_region == RGN_CFG);
  assign wr_diag  = acc_wr && (req_region == RGN_DIAG);
  assign wr_modem = acc_wr && (req_region == RGN_MODEM);
  assign wr_aux1  = acc_wr && (req_region == RGN_AUX1);
  assign wr_aux2  = acc_wr && (req_region == RGN_AUX2);
  assign wr_led   = acc_wr && (req_region == RGN_LED) && at_base;
  assign wr_sys   = acc_wr && (req_region == RGN_SYSCTL) && at_base;

  // Registers cleared by block reset
  logic [BYTE_W-1:0] cfg_q, aux1_q, modem_q;
  logic              aux2_off_q;
  logic              tc_q, shut_q, rstreq_q;

  always_ff @(posedge clk or negedge blk_rst_n) begin
    if (!blk_rst_n) begin
      cfg_q      <= '0;
      aux1_q     <= '0;
      modem_q    <= '0;
      aux2_off_q <= 1'b0;
      tc_q       <= 1'b0;
      shut_q     <= 1'b0;
      rstreq_q   <= 1'b0;
    end else begin
      if (wr_cfg)   cfg_q   <= req_wdata[BYTE_W-1:0];
      if (wr_modem) modem_q <= req_wdata[BYTE_W-1:0];
      if (wr_aux1)
        aux1_q <= req_wdata[BYTE_W-1:0] & ~(BYTE_W'(1) << AUX1_TC_BIT);
      if (wr_aux2)  aux2_off_q <= req_wdata[AUX2_OFF_BIT];
      tc_q     <= wr_aux1 && req_wdata[AUX1_TC_BIT];
      shut_q   <= wr_aux2 && req_wdata[AUX2_OFF_BIT];
      rstreq_q <= wr_sys && req_wdata[SYS_TRIG_BIT];
    end
  end

  // Registers cleared only at power-on
  logic [BYTE_W-1:0] diag_q, sys_q;
  logic [LED_W-1:0]  led_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      diag_q <= '0;
      sys_q  <= '0;
      led_q  <= '0;
    end else begin
      if (wr_diag) diag_q <= req_wdata[BYTE_W-1:0];
      if (wr_led)  led_q  <= req_wdata[LED_W-1:0];
      if (wr_sys && req_wdata[SYS_TRIG_BIT]) sys_q <= SYS_STATUS_VAL;
    end
  end

  // Power-fail path
  logic fail_sync, pf_flag;

  aux_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (blk_rst_n),
    .d_i    (pwr_fail_i),
    .q_o    (fail_sync)
  );

  aux_pwrfail_unit u_pwr (
    .clk         (clk),
    .arst_n      (blk_rst_n),
    .fail_sync_i (fail_sync),
    .enable_i    (cfg_q[CFG_PWR_EN_BIT]),
    .clear_i     (wr_aux2 && req_wdata[AUX2_CLR_BIT]),
    .flag_o      (pf_flag),
    .irq_o       (pwr_irq_o)
  );

  // Readback
  logic [BYTE_W-1:0] aux2_view;
  always_comb begin
    aux2_view = '0;
    aux2_view[AUX2_OFF_BIT]  = aux2_off_q;
    aux2_view[AUX2_FLAG_BIT] = pf_flag;
  end

  always_comb begin
    rd_data = '0;
    if (acc_rd) begin
      case (req_region)
        RGN_CFG:    rd_data = DATA_W'(cfg_q);
        RGN_DIAG:   rd_data = DATA_W'(diag_q);
        RGN_MODEM:  rd_data = DATA_W'(modem_q);
        RGN_AUX1:   rd_data = DATA_W'(aux1_q);
        RGN_AUX2:   rd_data = DATA_W'(aux2_view);
        RGN_LED:    rd_data = at_base ? DATA_W'(led_q) : '0;
        RGN_SYSCTL: rd_data = at_base ? DATA_W'(sys_q) : '0;
        default:    rd_data = '0;
      endcase
    end
  end

  assign tc_pulse_o     = tc_q;
  assign shutdown_req_o = shut_q;
  assign reset_req_o    = rstreq_q;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!blk_rst_n)
    pwr_irq_o |-> cfg_q[CFG_PWR_EN_BIT]);  // R1
  AST_TC_FROM_WRITE: assert property (@(posedge clk) disable iff (!blk_rst_n)
    tc_q |-> $past(wr_aux1 && req_wdata[AUX1_TC_BIT]));  // R3
  AST_TC_NOT_STORED: assert property (@(posedge clk) disable iff (!blk_rst_n)
    wr_aux1 |=> !aux1_q[AUX1_TC_BIT]);  // R3
  AST_SHUTDOWN_MATCHES_OFF: assert property (@(posedge clk) disable iff (!blk_rst_n)
    shut_q |-> aux2_off_q);  // R5
  AST_RESETREQ_STATUS: assert property (@(posedge clk) disable iff (!blk_rst_n)
    rstreq_q |-> (sys_q == SYS_STATUS_VAL));  // R6
  AST_BADSIZE_DIAG_KEPT: assert property (@(posedge clk) disable iff (!blk_rst_n)
    (req_valid && req_write && req_region == RGN_DIAG && req_size != SZ_BYTE)
      |=> $stable(diag_q));  // R8
endmodule

// File: tb/aux_sysctl_regs_tb_top.sv
module aux_sysctl_regs_tb_top;
  import aux_sysctl_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_region = '0;
  logic [1:0]  req_size = '0, req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        pwr_fail_i = 1'b0;
  logic        pwr_irq_o, tc_pulse_o, shutdown_req_o, reset_req_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  aux_sysctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .req_valid(req_valid), .req_write(req_write), .req_region(req_region),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .pwr_fail_i(pwr_fail_i), .pwr_irq_o(pwr_irq_o),
    .tc_pulse_o(tc_pulse_o), .shutdown_req_o(shutdown_req_o),
    .reset_req_o(reset_req_o)
  );

  typedef struct packed {
    logic [2:0]  rgn;
    logic [1:0]  wsz;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [1:0]  rsz;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{RGN_CFG,    SZ_BYTE, 2'd0, 32'h000000A5, SZ_BYTE, 32'h000000A5, 4'd10}, // R10
    '{RGN_DIAG,   SZ_BYTE, 2'd1, 32'h0000003C, SZ_BYTE, 32'h0000003C, 4'd10}, // R10
    '{RGN_MODEM,  SZ_BYTE, 2'd0, 32'h000000FF, SZ_BYTE, 32'h000000FF, 4'd10}, // R10
    '{RGN_AUX1,   SZ_BYTE, 2'd0, 32'h000000FF, SZ_BYTE, 32'h000000FD, 4'd3},  // R3
    '{RGN_AUX2,   SZ_BYTE, 2'd0, 32'h000000FF, SZ_BYTE, 32'h00000001, 4'd4},  // R4
    '{RGN_AUX2,   SZ_BYTE, 2'd0, 32'h00000002, SZ_BYTE, 32'h00000000, 4'd4},  // R4
    '{RGN_LED,    SZ_HALF, 2'd0, 32'h0000BEEF, SZ_HALF, 32'h0000BEEF, 4'd10}, // R10
    '{RGN_LED,    SZ_HALF, 2'd2, 32'h00001234, SZ_HALF, 32'h00000000, 4'd9},  // R9
    '{RGN_LED,    SZ_BYTE, 2'd0, 32'h00000055, SZ_HALF, 32'h0000BEEF, 4'd8},  // R8
    '{RGN_DIAG,   SZ_HALF, 2'd0, 32'h00000011, SZ_BYTE, 32'h0000003C, 4'd8},  // R8
    '{RGN_DIAG,   SZ_BYTE, 2'd0, 32'h0000003C, SZ_WORD, 32'h00000000, 4'd8},  // R8
    '{RGN_SYSCTL, SZ_WORD, 2'd0, 32'hFFFFFFFE, SZ_WORD, 32'h00000000, 4'd6},  // R6
    '{RGN_SYSCTL, SZ_WORD, 2'd2, 32'h00000001, SZ_WORD, 32'h00000000, 4'd9},  // R9
    '{RGN_SYSCTL, SZ_WORD, 2'd0, 32'h00000001, SZ_WORD, 32'h00000002, 4'd6}   // R6
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] rg, input logic [1:0] sz,
                          input logic [1:0] ad, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_region = rg;
    req_size = sz; req_addr = ad; req_wdata = wd;
    @(posedge clk);
    #1 req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] rg, input logic [1:0] sz,
                         input logic [1:0] ad, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_region = rg;
    req_size = sz; req_addr = ad;
    #1 rd = rd_data;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 por_n = 1'b1; rst_n = 1'b1;

    // R7 power-on state
    for (int g = 0; g < 7; g++) begin
      logic [1:0] sz;
      sz = (g == 5) ? SZ_HALF : (g == 6) ? SZ_WORD : SZ_BYTE;
      do_read(3'(g), sz, 2'd0, r);
      check("R7 power-on register zero", r, 32'h0);
    end
    check("R7 irq low after power-on", {31'b0, pwr_irq_o}, 32'h0);

    // Vector table: write then read back
    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].rgn, VECS[i].wsz, VECS[i].addr, VECS[i].wdata);
      do_read(VECS[i].rgn, VECS[i].rsz, VECS[i].addr, r);
      n_chk++;
      if (r !== VECS[i].exp) begin
        n_fail++;
        $display("FAIL R%0d vector %0d got=%h expected=%h", VECS[i].req, i, r, VECS[i].exp);
      end
    end

    // R3 terminal-count pulse lasts one clock
    do_write(RGN_AUX1, SZ_BYTE, 2'd0, 32'h02);
    check("R3 tc pulse high", {31'b0, tc_pulse_o}, 32'h1);
    @(posedge clk); #1;
    check("R3 tc pulse gone", {31'b0, tc_pulse_o}, 32'h0);

    // R5 shutdown pulse
    do_write(RGN_AUX2, SZ_BYTE, 2'd0, 32'h01);
    check("R5 shutdown pulse high", {31'b0, shutdown_req_o}, 32'h1);
    @(posedge clk); #1;
    check("R5 shutdown pulse gone", {31'b0, shutdown_req_o}, 32'h0);

    // R6 reset request pulse
    do_write(RGN_SYSCTL, SZ_WORD, 2'd0, 32'h01);
    check("R6 reset request high", {31'b0, reset_req_o}, 32'h1);
    @(posedge clk); #1;
    check("R6 reset request gone", {31'b0, reset_req_o}, 32'h0);
    do_write(RGN_AUX2, SZ_BYTE, 2'd0, 32'h00);

    // R2 enable gates the flag
    do_write(RGN_CFG, SZ_BYTE, 2'd0, 32'h00);
    pwr_fail_i = 1'b1;
    repeat (4) @(posedge clk); #1;
    check("R2 irq stays low without enable", {31'b0, pwr_irq_o}, 32'h0);
    do_read(RGN_AUX2, SZ_BYTE, 2'd0, r);
    check("R2 flag stays low without enable", r, 32'h00);
    pwr_fail_i = 1'b0;
    repeat (4) @(posedge clk);

    // R1 / R2 / R4 power-fail path with enable
    do_write(RGN_CFG, SZ_BYTE, 2'd0, 32'h08);
    pwr_fail_i = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R2 flag not yet visible", {31'b0, pwr_irq_o}, 32'h0);
    @(posedge clk); #1;
    check("R1 irq high with flag and enable", {31'b0, pwr_irq_o}, 32'h1);
    do_read(RGN_AUX2, SZ_BYTE, 2'd0, r);
    check("R4 flag reads in bit 5", r, 32'h20);
    do_write(RGN_AUX2, SZ_BYTE, 2'd0, 32'h02);
    check("R4 clear write drops flag", {31'b0, pwr_irq_o}, 32'h0);
    @(posedge clk); #1;
    check("R2 flag re-evaluated while failing", {31'b0, pwr_irq_o}, 32'h1);
    do_write(RGN_CFG, SZ_BYTE, 2'd0, 32'h00);
    check("R1 disabling drops irq", {31'b0, pwr_irq_o}, 32'h0);
    pwr_fail_i = 1'b0;
    do_write(RGN_CFG, SZ_BYTE, 2'd0, 32'h08);
    repeat (4) @(posedge clk); #1;
    check("R2 flag follows released input", {31'b0, pwr_irq_o}, 32'h0);

    // R7 block reset keeps diag, LED, system-control
    do_write(RGN_DIAG,  SZ_BYTE, 2'd0, 32'h5A);
    do_write(RGN_MODEM, SZ_BYTE, 2'd0, 32'h77);
    do_write(RGN_AUX1,  SZ_BYTE, 2'd0, 32'h80);
    do_write(RGN_LED,   SZ_HALF, 2'd0, 32'h1234);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_read(RGN_CFG, SZ_BYTE, 2'd0, r);    check("R7 config cleared", r, 32'h0);
    do_read(RGN_MODEM, SZ_BYTE, 2'd0, r);  check("R7 modem cleared", r, 32'h0);
    do_read(RGN_AUX1, SZ_BYTE, 2'd0, r);   check("R7 aux1 cleared", r, 32'h0);
    do_read(RGN_DIAG, SZ_BYTE, 2'd0, r);   check("R7 diag kept", r, 32'h5A);
    do_read(RGN_LED, SZ_HALF, 2'd0, r);    check("R7 led kept", r, 32'h1234);
    do_read(RGN_SYSCTL, SZ_WORD, 2'd0, r); check("R7 sysctl status kept", r, 32'h2);

    finish_run();
  end
endmodule